// File: doc/BRIEF.md
# Page Load Buffer with Inactivity Close

This block gathers the words of one page program operation once the command layer has recognised a program request and pulses `arm_i`. A page holds 64 words of 16 bits. Each word arrives as two strobe events: a start event that carries the 20-bit word address, and an end event that carries the data. The low six address bits pick the slot inside the page and the upper fourteen bits name the page. Words may arrive in any order, and a slot written twice keeps its last data.

The first accepted word fixes the page. A later word that names a different page is dropped and raises a sticky error. A gap counter measures the idle time between the end of one write and the start of the next. A start that comes later than a soft limit raises a sticky late flag. When the hard limit passes with no new start, the load window closes. If at least one word was taken, a one-cycle start-program pulse is issued. The page number, the 64-word image (slots never written read as the erased value FFFFh) and the per-slot loaded mask stay on the outputs for the programming engine.

Top module: `page_load_buffer`

## Requirements
- R1: After reset `loading_o`, `prog_start_o`, `page_err_o` and `gap_late_o` are low, `loaded_mask_o` is all zero and every image slot reads FFFFh.
- R2: An `arm_i` pulse opens a load window: from the next cycle `loading_o` is high, the mask is zero, every slot reads FFFFh and both flags are low, even if a window was already open.
- R3: In an open window, a start event latches the address and the following end event writes `data_i` into slot `addr_i[5:0]`, found at `page_image_o[16*slot +: 16]`, and sets `loaded_mask_o[slot]`. Slots may be filled in any order. Start and end events are never high in the same cycle.
- R4: A second write to a slot already loaded replaces its data with the newer value.
- R5: The first accepted word sets `page_addr_o` to its `addr_i[19:6]`. A later start whose `addr_i[19:6]` differs sets `page_err_o`, and that word changes neither image nor mask. The flag stays high until the next `arm_i`.
- R6: If no start event is sampled within `TIMEOUT_CYC` clock edges after the edge that took the last end event (or the arm pulse), `loading_o` falls after edge `TIMEOUT_CYC`. If the mask is non-zero, `prog_start_o` is high for exactly that one cycle. Page, image and mask then hold.
- R7: A start event sampled more than `LATE_CYC` edges after the previous end event (or the arm pulse) sets `gap_late_o`. A start at exactly `LATE_CYC` edges does not. The flag stays high until the next `arm_i`.
- R8: A window that closes with no word loaded gives no `prog_start_o` pulse.
- R9: Start and end events outside a load window change neither image, mask, page, error flag nor `prog_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Opens (or restarts) a load window |
| wr_fall_i | input | 1 | Write start event; address valid |
| wr_rise_i | input | 1 | Write end event; data valid |
| addr_i | input | 20 | Word address: page in [19:6], slot in [5:0] |
| data_i | input | 16 | Word data, taken on the end event |
| loading_o | output | 1 | Load window open |
| prog_start_o | output | 1 | One-cycle start-program pulse |
| page_addr_o | output | 14 | Page number of the loaded image |
| page_image_o | output | 1024 | 64 slots of 16 bits, slot n at [16n+15:16n] |
| loaded_mask_o | output | 64 | One bit per slot that was written |
| page_err_o | output | 1 | Sticky page-mismatch flag |
| gap_late_o | output | 1 | Sticky late-start flag |

## Verification
The assertions assume that a start event and an end event never share a cycle, and that each end event follows its own start event. The bench drives every write as a start pulse in one cycle and an end pulse in the next, with inputs changed only on the falling clock edge. Inter-write gaps stay below the hard limit unless a close is intended. The late and timeout limits are probed exactly one edge either side of their thresholds.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int WORD_W     = 16;
  localparam int IDX_W      = 6;
  localparam int PAGE_WORDS = 1 << IDX_W;
  localparam int ADDR_W     = 20;
  localparam int PAGE_W     = ADDR_W - IDX_W;
  localparam logic [WORD_W-1:0] ERASED_WORD = '1;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_WAIT  = 2'd1,
    LD_WRITE = 2'd2
  } ld_state_e;

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic over_limit(input int unsigned idle_cnt, input int unsigned limit);
    return idle_cnt >= limit;
  endfunction
endpackage

// File: rtl/plb_gap_timer.sv
module plb_gap_timer #(
  parameter int TIMEOUT_CYC = 20000,
  parameter int LATE_CYC    = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o,
  output logic late_o
);
  import plb_pkg::*;
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] idle_q;

  assign expire_o = run_i && (idle_q == LAST);
  assign late_o   = over_limit(int'(idle_q), LATE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_q <= '0;
    else if (restart_i)         idle_q <= '0;
    else if (run_i && !expire_o) idle_q <= idle_q + 1'b1;
  end

  // R6: the idle count never passes the closing value
  assert_idle_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= LAST);

  // R6: a restart always brings the count back to zero
  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (idle_q == '0));
endmodule

// File: rtl/plb_word_store.sv
module plb_word_store
  import plb_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [WORD_W-1:0]            data_i,
  output logic [PAGE_WORDS*WORD_W-1:0] image_o,
  output logic [PAGE_WORDS-1:0]        mask_o
);
  logic [WORD_W-1:0]     word_q [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] mask_q;

  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= ERASED_WORD;
        mask_q[w] <= 1'b0;
      end else if (clr_i) begin
        word_q[w] <= ERASED_WORD;
        mask_q[w] <= 1'b0;
      end else if (we_i && (idx_i == IDX_W'(w))) begin
        word_q[w] <= data_i;
        mask_q[w] <= 1'b1;
      end
    end
    assign image_o[w*WORD_W +: WORD_W] = word_q[w];
  end

  assign mask_o = mask_q;

  // R3: a write marks its slot as loaded
  assert_write_marks_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i) |=> mask_q[$past(idx_i)]);

  // R3: loaded bits only drop on a clear
  assert_mask_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (($past(mask_q) & ~mask_q) == '0));

  // R2: a clear empties the mask
  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_q == '0));
endmodule

// File: rtl/plb_ctrl.sv
module plb_ctrl
  import plb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              expire_i,
  input  logic              late_i,
  input  logic              mask_any_i,
  output logic              clr_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              timer_restart_o,
  output logic              timer_run_o,
  output logic              loading_o,
  output logic              prog_start_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              page_err_o,
  output logic              late_o
);
  ld_state_e         state_q;
  logic              have_page_q;
  logic              pend_ok_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [PAGE_W-1:0] page_q;
  logic              err_q, late_q, prog_q;

  logic start_seen, end_seen, page_clash;
  assign start_seen = !arm_i && (state_q == LD_WAIT) && fall_i;
  assign end_seen   = !arm_i && (state_q == LD_WRITE) && rise_i;
  assign page_clash = have_page_q && (page_of(addr_i) != page_q);

  assign clr_o           = arm_i;
  assign we_o            = end_seen && pend_ok_q;
  assign idx_o           = pend_idx_q;
  assign timer_restart_o = arm_i || end_seen;
  assign timer_run_o     = !arm_i && (state_q == LD_WAIT) && !fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LD_IDLE;
      have_page_q <= 1'b0;
      pend_ok_q   <= 1'b0;
      pend_idx_q  <= '0;
      page_q      <= '0;
      err_q       <= 1'b0;
      late_q      <= 1'b0;
      prog_q      <= 1'b0;
    end else begin
      prog_q <= 1'b0;
      if (arm_i) begin
        state_q     <= LD_WAIT;
        have_page_q <= 1'b0;
        pend_ok_q   <= 1'b0;
        err_q       <= 1'b0;
        late_q      <= 1'b0;
      end else begin
        unique case (state_q)
          LD_WAIT: begin
            if (fall_i) begin
              state_q    <= LD_WRITE;
              pend_idx_q <= slot_of(addr_i);
              pend_ok_q  <= !page_clash;
              if (late_i) late_q <= 1'b1;
              if (page_clash) err_q <= 1'b1;
              if (!have_page_q) begin
                have_page_q <= 1'b1;
                page_q      <= page_of(addr_i);
              end
            end else if (expire_i) begin
              state_q <= LD_IDLE;
              prog_q  <= mask_any_i;
            end
          end
          LD_WRITE: if (rise_i) state_q <= LD_WAIT;
          default: ;
        endcase
      end
    end
  end

  assign loading_o    = (state_q != LD_IDLE);
  assign prog_start_o = prog_q;
  assign page_o       = page_q;
  assign page_err_o   = err_q;
  assign late_o       = late_q;

  // R6: the timer expiry closes the window
  assert_expire_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !arm_i) |=> (state_q == LD_IDLE));

  // R6: the start pulse lasts one cycle
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> !prog_q);

  // R8: no pulse unless a word was loaded
  assert_pulse_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_q) |-> $past(mask_any_i));

  // R5: the mismatch flag holds until the next arm
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !arm_i) |=> err_q);

  // R7: the late flag holds until the next arm
  assert_late_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (late_q && !arm_i) |=> late_q);

  // R9: no store write outside a window
  assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_IDLE) |-> !we_o);
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
  import plb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20000,
  parameter int LATE_CYC    = 6000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         arm_i,
  input  logic                         wr_fall_i,
  input  logic                         wr_rise_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            data_i,
  output logic                         loading_o,
  output logic                         prog_start_o,
  output logic [PAGE_W-1:0]            page_addr_o,
  output logic [PAGE_WORDS*WORD_W-1:0] page_image_o,
  output logic [PAGE_WORDS-1:0]        loaded_mask_o,
  output logic                         page_err_o,
  output logic                         gap_late_o
);
  logic             clr, we, restart, run, expire, late_now;
  logic [IDX_W-1:0] idx;
  logic [PAGE_WORDS-1:0] mask;

  plb_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .LATE_CYC(LATE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (run),
    .expire_o  (expire),
    .late_o    (late_now)
  );

  plb_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .arm_i           (arm_i),
    .fall_i          (wr_fall_i),
    .rise_i          (wr_rise_i),
    .addr_i          (addr_i),
    .expire_i        (expire),
    .late_i          (late_now),
    .mask_any_i      (|mask),
    .clr_o           (clr),
    .we_o            (we),
    .idx_o           (idx),
    .timer_restart_o (restart),
    .timer_run_o     (run),
    .loading_o       (loading_o),
    .prog_start_o    (prog_start_o),
    .page_o          (page_addr_o),
    .page_err_o      (page_err_o),
    .late_o          (gap_late_o)
  );

  plb_word_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .we_i    (we),
    .idx_i   (idx),
    .data_i  (data_i),
    .image_o (page_image_o),
    .mask_o  (mask)
  );

  assign loaded_mask_o = mask;

  // R3: start and end events are kept apart
  assert_events_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fall_i && wr_rise_i));

  // R6: the pulse comes with the window closing
  assert_pulse_when_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> !loading_o);
endmodule

// File: tb/test_page_load_buffer.sv
module test_page_load_buffer;
  localparam int TMO  = 30;
  localparam int LATE = 8;
  localparam logic [13:0] PA = 14'h0ABC;
  localparam logic [13:0] PB = 14'h1234;
  localparam logic [13:0] PC = 14'h1235;

  // {slot, data, gap}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {6'd5,  16'h1111, 8'd0},
    {6'd63, 16'h2222, 8'd3},
    {6'd0,  16'h0000, 8'd1},
    {6'd17, 16'hA5A5, 8'd7},
    {6'd5,  16'h5A5A, 8'd2},
    {6'd32, 16'hBEEF, 8'd0},
    {6'd1,  16'h0001, 8'd5},
    {6'd62, 16'hC0DE, 8'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, fall = 1'b0, rise = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic loading, prog;
  logic [13:0] page;
  logic [1023:0] image;
  logic [63:0] mask;
  logic perr, plate;

  int n_chk = 0, n_bad = 0, n_prog = 0;
  logic [15:0] exp_img [64];
  logic [63:0] exp_mask;

  always #2.5 clk = ~clk;

  page_load_buffer #(.TIMEOUT_CYC(TMO), .LATE_CYC(LATE)) i_page_load_buffer (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .wr_fall_i(fall), .wr_rise_i(rise),
    .addr_i(addr), .data_i(data), .loading_o(loading), .prog_start_o(prog),
    .page_addr_o(page), .page_image_o(image), .loaded_mask_o(mask),
    .page_err_o(perr), .gap_late_o(plate)
  );

  always @(negedge clk) if (prog) n_prog++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d);
    addr = a; fall = 1'b1; @(negedge clk);
    fall = 1'b0; rise = 1'b1; data = d; @(negedge clk);
    rise = 1'b0;
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 64; i++) exp_img[i] = 16'hFFFF;
    exp_mask = '0;
  endtask

  task automatic chk_image(input string req);
    for (int i = 0; i < 64; i++) chk(req, 64'(image[i*16 +: 16]), 64'(exp_img[i]));
    chk(req, mask, exp_mask);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p0;
    clear_exp();
    idle(3);
    // R1 reset state
    chk("R1 loading", 64'(loading), 64'd0);
    chk("R1 prog", 64'(prog), 64'd0);
    chk("R1 err", 64'(perr), 64'd0);
    chk("R1 late", 64'(plate), 64'd0);
    chk_image("R1 image");
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 R6: table-driven session, any order, overwrite on slot 5
    do_arm();
    chk("R2 loading", 64'(loading), 64'd1);
    for (int v = 0; v < NV; v++) begin
      idle(int'(VEC[v][7:0]));
      do_write({PA, VEC[v][29:24]}, VEC[v][23:8]);
      exp_img[VEC[v][29:24]] = VEC[v][23:8];
      exp_mask[VEC[v][29:24]] = 1'b1;
    end
    p0 = n_prog;
    idle(TMO - 1);
    chk("R6 still loading", 64'(loading), 64'd1);
    chk("R6 no early pulse", 64'(prog), 64'd0);
    idle(1);
    chk("R6 closed", 64'(loading), 64'd0);
    chk("R6 pulse", 64'(prog), 64'd1);
    idle(1);
    chk("R6 pulse one cycle", 64'(prog), 64'd0);
    chk("R6 one pulse", 64'(n_prog - p0), 64'd1);
    chk("R5 page", 64'(page), 64'(PA));
    chk("R7 no late", 64'(plate), 64'd0);
    chk("R5 no err", 64'(perr), 64'd0);
    chk_image("R3 R4 image");

    // R9: writes outside a window are ignored
    p0 = n_prog;
    do_write({PB, 6'd5}, 16'h7777);
    do_write({PB, 6'd9}, 16'h8888);
    idle(TMO + 2);
    chk_image("R9 image held");
    chk("R9 page held", 64'(page), 64'(PA));
    chk("R9 err", 64'(perr), 64'd0);
    chk("R9 no pulse", 64'(n_prog - p0), 64'd0);

    // R5: page mismatch
    clear_exp();
    do_arm();
    do_write({PB, 6'd3}, 16'h1111);
    chk("R5 err clear", 64'(perr), 64'd0);
    do_write({PC, 6'd4}, 16'h2222);
    chk("R5 err set", 64'(perr), 64'd1);
    do_write({PB, 6'd9}, 16'h3333);
    chk("R5 err sticky", 64'(perr), 64'd1);
    exp_img[3] = 16'h1111; exp_mask[3] = 1'b1;
    exp_img[9] = 16'h3333; exp_mask[9] = 1'b1;
    p0 = n_prog;
    idle(TMO + 1);
    chk("R5 pulse", 64'(n_prog - p0), 64'd1);
    chk("R5 page", 64'(page), 64'(PB));
    chk_image("R5 image");

    // R7: late threshold
    clear_exp();
    do_arm();
    chk("R2 err cleared", 64'(perr), 64'd0);
    do_write({PA, 6'd0}, 16'h0F0F);
    idle(LATE - 1);
    do_write({PA, 6'd1}, 16'hF0F0);
    chk("R7 at limit", 64'(plate), 64'd0);
    idle(LATE);
    do_write({PA, 6'd2}, 16'h1234);
    chk("R7 past limit", 64'(plate), 64'd1);
    idle(TMO + 1);
    chk("R7 held after close", 64'(plate), 64'd1);

    // R2: arm inside a window restarts it
    do_arm();
    do_write({PB, 6'd7}, 16'hABCD);
    chk("R2 slot loaded", 64'(mask), 64'd1 << 7);
    do_arm();
    chk("R2 re-arm mask", 64'(mask), 64'd0);
    chk("R2 re-arm slot", 64'(image[7*16 +: 16]), 64'hFFFF);
    chk("R2 re-arm loading", 64'(loading), 64'd1);
    chk("R2 late cleared", 64'(plate), 64'd0);

    // R8: empty window closes silently
    p0 = n_prog;
    idle(TMO - 1);
    chk("R8 open", 64'(loading), 64'd1);
    idle(1);
    chk("R8 closed", 64'(loading), 64'd0);
    idle(3);
    chk("R8 no pulse", 64'(n_prog - p0), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule